// File: doc/BRIEF.md
# IO Virtual Address Translator

This block turns an IO virtual address presented by a DMA agent into a physical page address by looking up a single 64-bit entry in a translation table that lives in system memory. Software sets up the table location, the table size and the indexing granularity through three 64-bit registers, which can be reached with 32-bit or 64-bit accesses. Each lookup returns four things: the page-aligned IO address, the physical page address, the page offset mask and an access permission.

Only one lookup is in flight at a time. The state machine has three states. ST_IDLE accepts a request. ST_FETCH holds a memory read of the table entry. ST_RESP holds the result until the consumer accepts it. From ST_IDLE there are two transitions. A request taken with translation disabled, or with an unsupported table-size code, goes straight to ST_RESP. Any other accepted request goes to ST_FETCH. ST_FETCH moves to ST_RESP when the memory returns data or an error. ST_RESP returns to ST_IDLE when the result is accepted.

Top module: `iova_xlate`

## Requirements
- R1: After reset, the control and table-base registers read as zero, req_ready is 1, and both rsp_valid and mem_req are 0.
- R2: Register accesses use the following rules.
  - Register offsets are control 0x00, table base 0x08 and flush 0x10.
  - A 32-bit access (reg_wide=0) at a register's offset reaches bits 63:32. The data travels in bits 31:0 of reg_wdata and reg_rdata.
  - An access at offset+4, of either width, reaches bits 31:0 only.
  - A 64-bit access at the register's offset reaches the whole register.
  - A write to one half leaves the other half unchanged.
- R3: Writes to the flush offsets (0x10 and 0x14) and to any other offset change no register. Reads of them return zero.
- R4: When control bit 0 is clear, a request is answered one cycle after it is accepted, and no memory read is made. The response carries:
  - pa = the request address;
  - iova = the address with bits 12:0 cleared;
  - mask = 0x1FFF;
  - perm = read-write.
- R5: When control bit 2 is clear (8K indexing) and translation is enabled, the entry is read at table base + ((addr AND bits 22+code..13) >> 10). Here code is control bits 18:16. mem_addr stays stable while mem_req waits for mem_rvalid.
- R6: When control bit 2 is set (64K indexing), codes 0 to 5 read the entry at table base + ((addr AND bits 25+code..16) >> 13). Codes 6 and 7 give a fault response one cycle after acceptance, with no memory read.
- R7: An entry with bit 63 clear gives a fault response: perm none, iova 0, pa 0, mask all ones. A valid entry gives read-write if bit 1 is set and read-only otherwise. The perm encoding is none = 2'b00, read-only = 2'b01, read-write = 2'b11.
- R8: Entry bit 61 selects the page size for a valid entry.
  - Bit 61 clear: pa = entry bits 40:13, mask = 0x1FFF.
  - Bit 61 set: pa = entry bits 40:15, mask = 0xFFFF.
  - In both cases iova = addr AND NOT mask.
- R9: A memory read that returns mem_rerr=1 gives a fault response with perm none.
- R10: req_ready is high only in ST_IDLE. Once rsp_valid rises, it and all response fields stay unchanged until rsp_ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 64 | Write data (32-bit data in bits 31:0) |
| reg_rdata | output | 64 | Combinational read data for reg_addr |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | 64 | IO virtual address |
| mem_req | output | 1 | Table entry read request |
| mem_addr | output | 64 | Byte address of the table entry |
| mem_rvalid | input | 1 | Read data or error returned |
| mem_rdata | input | 64 | Entry as a big-endian word: the lowest-addressed byte in bits 63:56 |
| mem_rerr | input | 1 | Read error, qualified by mem_rvalid |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Consumer accepts the result |
| rsp_iova | output | 64 | Page-aligned IO address |
| rsp_pa | output | 64 | Physical page address |
| rsp_mask | output | 64 | Page offset mask |
| rsp_perm | output | 2 | Permission: 00 none, 01 read-only, 11 read-write |

## Verification
A register write lands on the clock edge, so a read-back is valid from the next cycle; reads are combinational. A request that needs no table entry (R4, or codes 6 and 7 under R6) shows rsp_valid exactly one cycle after the accepting edge, and the bench checks it at the falling edge right after that acceptance. For table lookups, mem_req and mem_addr are checked one cycle after acceptance. The result is then checked one cycle after the edge that carries mem_rvalid. The hold test keeps rsp_ready low for several cycles and checks the outputs at each falling edge.

// File: rtl/iova_xlate_pkg.sv
`timescale 1ns/1ps
package iova_xlate_pkg;
    localparam int VA_W       = 64;
    localparam int REG_AW     = 5;
    localparam int SMALL_SH   = 13;
    localparam int BIG_SH     = 16;
    localparam int SMALL_SPAN = 9;   // index field reaches bit SMALL_SH+SMALL_SPAN+code
    localparam int BIG_SPAN   = 9;
    localparam int ENTRY_SH   = 3;   // 8-byte entries
    localparam int NCODES     = 8;
    localparam int BIG_CODES  = 6;
    localparam int PA_TOP     = 40;
    localparam int BIG_PA_LSB = 15;
    localparam int V_BIT      = 63;
    localparam int SZ_BIT     = 61;
    localparam int W_BIT      = 1;

    typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_RESP} xl_state_e;
    typedef enum logic [1:0] {PERM_NONE = 2'b00, PERM_RO = 2'b01, PERM_RW = 2'b11} perm_e;

    typedef struct packed {
        logic [VA_W-1:0] iova;
        logic [VA_W-1:0] pa;
        logic [VA_W-1:0] mask;
        perm_e           perm;
    } xl_result_t;

    function automatic logic [VA_W-1:0] span_mask(input int lo, input int hi);
        logic [VA_W-1:0] m;
        for (int i = 0; i < VA_W; i++) m[i] = (i >= lo) && (i <= hi);
        return m;
    endfunction
endpackage

// File: rtl/iova_xlate_regs.sv
`timescale 1ns/1ps
module iova_xlate_regs
    import iova_xlate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_wide,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [VA_W-1:0]   reg_wdata,
    output logic [VA_W-1:0]   reg_rdata,
    output logic              xl_en,
    output logic              tbl_big,
    output logic [2:0]        tbl_code,
    output logic [VA_W-1:0]   tbl_base
);
    localparam int HALF = VA_W / 2;

    logic [VA_W-1:0] ctrl_q, base_q, cur, merged;
    logic hit_ctrl, hit_base, lo_half;

    assign hit_ctrl = (reg_addr[4:3] == 2'd0) && (reg_addr[1:0] == 2'd0);
    assign hit_base = (reg_addr[4:3] == 2'd1) && (reg_addr[1:0] == 2'd0);
    assign lo_half  = reg_addr[2];
    assign cur      = hit_ctrl ? ctrl_q : (hit_base ? base_q : '0);

    always_comb begin
        merged = cur;
        if (lo_half)       merged[HALF-1:0]    = reg_wdata[HALF-1:0];
        else if (reg_wide) merged              = reg_wdata;
        else               merged[VA_W-1:HALF] = reg_wdata[HALF-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            base_q <= '0;
        end else if (reg_wr) begin
            if (hit_ctrl) ctrl_q <= merged;
            if (hit_base) base_q <= merged;
        end
    end

    always_comb begin
        if (lo_half)       reg_rdata = {{HALF{1'b0}}, cur[HALF-1:0]};
        else if (reg_wide) reg_rdata = cur;
        else               reg_rdata = {{HALF{1'b0}}, cur[VA_W-1:HALF]};
    end

    assign xl_en    = ctrl_q[0];
    assign tbl_big  = ctrl_q[2];
    assign tbl_code = ctrl_q[18:16];
    assign tbl_base = base_q;

    // R3: flush and unmapped writes leave both registers untouched
    p_flush_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr[4:3] >= 2'd2) |=> ($stable(ctrl_q) && $stable(base_q)));

    // R2: a lower-half write keeps the upper half of the control register
    p_lo_keeps_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 5'h04) |=> (ctrl_q[VA_W-1:HALF] == $past(ctrl_q[VA_W-1:HALF])));
endmodule

// File: rtl/iova_xlate_index.sv
`timescale 1ns/1ps
module iova_xlate_index
    import iova_xlate_pkg::*;
(
    input  logic [VA_W-1:0] va,
    input  logic [VA_W-1:0] base,
    input  logic            big,
    input  logic [2:0]      code,
    output logic [VA_W-1:0] entry_addr,
    output logic            code_bad
);
    logic [VA_W-1:0] small_m [NCODES];
    logic [VA_W-1:0] big_m   [NCODES];
    logic [VA_W-1:0] off;

    for (genvar g = 0; g < NCODES; g++) begin : g_masks
        assign small_m[g] = span_mask(SMALL_SH, SMALL_SH + SMALL_SPAN + g);
        assign big_m[g]   = span_mask(BIG_SH, BIG_SH + BIG_SPAN + g);
    end

    always_comb begin
        if (big) begin
            off      = (va & big_m[code]) >> (BIG_SH - ENTRY_SH);
            code_bad = (int'(code) >= BIG_CODES);
        end else begin
            off      = (va & small_m[code]) >> (SMALL_SH - ENTRY_SH);
            code_bad = 1'b0;
        end
        entry_addr = base + off;
    end
endmodule

// File: rtl/iova_xlate.sv
`timescale 1ns/1ps
module iova_xlate
    import iova_xlate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_wide,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [VA_W-1:0]   reg_wdata,
    output logic [VA_W-1:0]   reg_rdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_addr,
    output logic              mem_req,
    output logic [VA_W-1:0]   mem_addr,
    input  logic              mem_rvalid,
    input  logic [VA_W-1:0]   mem_rdata,
    input  logic              mem_rerr,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [VA_W-1:0]   rsp_iova,
    output logic [VA_W-1:0]   rsp_pa,
    output logic [VA_W-1:0]   rsp_mask,
    output logic [1:0]        rsp_perm
);
    localparam logic [VA_W-1:0] SMALL_MASK = (VA_W'(1) << SMALL_SH) - 1;
    localparam logic [VA_W-1:0] BIG_MASK   = (VA_W'(1) << BIG_SH) - 1;

    xl_state_e       state_q, state_d;
    xl_result_t      res_q, fault_res, pass_res, ent_res;
    logic [VA_W-1:0] va_q, addr_q, entry_addr, tbl_base;
    logic            xl_en, tbl_big, code_bad;
    logic [2:0]      tbl_code;
    logic            take;

    iova_xlate_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wide(reg_wide),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .xl_en(xl_en), .tbl_big(tbl_big), .tbl_code(tbl_code), .tbl_base(tbl_base)
    );

    iova_xlate_index u_index (
        .va(req_addr), .base(tbl_base), .big(tbl_big), .code(tbl_code),
        .entry_addr(entry_addr), .code_bad(code_bad)
    );

    assign take = req_valid && (state_q == ST_IDLE);

    always_comb begin
        fault_res = '{iova: '0, pa: '0, mask: '1, perm: PERM_NONE};
        pass_res  = '{iova: req_addr & ~SMALL_MASK, pa: req_addr,
                      mask: SMALL_MASK, perm: PERM_RW};
        if (mem_rerr || !mem_rdata[V_BIT]) begin
            ent_res = fault_res;
        end else begin
            ent_res.mask = mem_rdata[SZ_BIT] ? BIG_MASK : SMALL_MASK;
            ent_res.iova = va_q & ~ent_res.mask;
            ent_res.pa   = mem_rdata[SZ_BIT] ? (mem_rdata & span_mask(BIG_PA_LSB, PA_TOP))
                                             : (mem_rdata & span_mask(SMALL_SH, PA_TOP));
            ent_res.perm = mem_rdata[W_BIT] ? PERM_RW : PERM_RO;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = (!xl_en || code_bad) ? ST_RESP : ST_FETCH;
            ST_FETCH: if (mem_rvalid) state_d = ST_RESP;
            ST_RESP:  if (rsp_ready) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q   <= '0;
            addr_q <= '0;
            res_q  <= '{iova: '0, pa: '0, mask: '0, perm: PERM_NONE};
        end else if (take) begin
            va_q   <= req_addr;
            addr_q <= entry_addr;
            if (!xl_en)        res_q <= pass_res;
            else if (code_bad) res_q <= fault_res;
        end else if (state_q == ST_FETCH && mem_rvalid) begin
            res_q <= ent_res;
        end
    end

    always_comb begin
        req_ready = (state_q == ST_IDLE);
        mem_req   = (state_q == ST_FETCH);
        rsp_valid = (state_q == ST_RESP);
        mem_addr  = addr_q;
        rsp_iova  = res_q.iova;
        rsp_pa    = res_q.pa;
        rsp_mask  = res_q.mask;
        rsp_perm  = res_q.perm;
    end

    p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!rsp_valid && !mem_req));

    p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa) && $stable(rsp_iova)
                                       && $stable(rsp_mask) && $stable(rsp_perm)));

    p_mem_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    p_fault_shape_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_perm == PERM_NONE) |-> (rsp_pa == '0 && rsp_mask == '1));

    p_mask_shape_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_perm != PERM_NONE) |-> (rsp_mask == SMALL_MASK || rsp_mask == BIG_MASK));

    p_err_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_rvalid && mem_rerr) |=> (rsp_valid && rsp_perm == PERM_NONE));

    p_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !xl_en) |=> (rsp_valid && rsp_pa == $past(req_addr)
                                                && rsp_perm == PERM_RW));
endmodule

// File: tb/iova_xlate_test.sv
`timescale 1ns/1ps
module iova_xlate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_wide = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0, reg_rdata;
    logic        req_valid = 1'b0, req_ready;
    logic [63:0] req_addr = '0;
    logic        mem_req, mem_rvalid = 1'b0, mem_rerr = 1'b0;
    logic [63:0] mem_addr, mem_rdata = '0;
    logic        rsp_valid, rsp_ready = 1'b0;
    logic [63:0] rsp_iova, rsp_pa, rsp_mask;
    logic [1:0]  rsp_perm;

    int total = 0, bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    iova_xlate uut (.*);

    typedef struct packed {
        logic [63:0] ctrl, base, va, ent;
        logic        rerr, use_mem;
        logic [63:0] maddr, iova, pa, mask;
        logic [1:0]  perm;
    } vec_t;

    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        // R4 pass-through
        '{64'h0, 64'h0, 64'h0000_1234_5678_9ABC, 64'h0, 1'b0, 1'b0,
          64'h0, 64'h0000_1234_5678_8000, 64'h0000_1234_5678_9ABC, 64'h1FFF, 2'b11},
        // R5 8K code 0, valid writable 8K entry
        '{64'h1, 64'h10_0000, 64'h12_3456, 64'h8000_00AB_CDEF_2002, 1'b0, 1'b1,
          64'h10_0488, 64'h12_2000, 64'hAB_CDEF_2000, 64'h1FFF, 2'b11},
        // R5 8K code 7, read-only, pa truncated at bit 40
        '{64'h7_0001, 64'h2000_0000, 64'hFFFF_FFFF_C000_6000, 64'h8000_FF00_0000_4000, 1'b0, 1'b1,
          64'h2000_0018, 64'hFFFF_FFFF_C000_6000, 64'h100_0000_4000, 64'h1FFF, 2'b01},
        // R6 64K code 0, R8 64K entry
        '{64'h5, 64'h4000, 64'h0345_6789, 64'hA000_0155_5555_FFFE, 1'b0, 1'b1,
          64'h5A28, 64'h0345_0000, 64'h155_5555_8000, 64'hFFFF, 2'b11},
        // R6 64K code 5, R7 invalid entry
        '{64'h5_0005, 64'h0, 64'h8765_4321, 64'h2000_0000_0000_0002, 1'b0, 1'b1,
          64'h3B28, 64'h0, 64'h0, ONES, 2'b00},
        // R8 8K table, 64K page entry, read-only
        '{64'h2_0001, 64'h8, 64'h01F0_E000, 64'hA000_0000_1234_5678, 1'b0, 1'b1,
          64'h7C40, 64'h01F0_0000, 64'h1234_0000, 64'hFFFF, 2'b01},
        // R9 memory error
        '{64'h1, 64'h0, 64'h2000, 64'h8000_0000_0000_2002, 1'b1, 1'b1,
          64'h8, 64'h0, 64'h0, ONES, 2'b00},
        // R6 code 6 unsupported
        '{64'h6_0005, 64'h1000, 64'hFFFF, 64'h0, 1'b0, 1'b0,
          64'h0, 64'h0, 64'h0, ONES, 2'b00},
        // R6 code 7 unsupported
        '{64'h7_0005, 64'h1000, 64'hFFFF, 64'h0, 1'b0, 1'b0,
          64'h0, 64'h0, 64'h0, ONES, 2'b00}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic w, input logic [63:0] d);
        reg_addr = a; reg_wide = w; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic w, output logic [63:0] d);
        reg_addr = a; reg_wide = w;
        #0.5 d = reg_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Runs one lookup; all sampling at falling edges.
    task automatic lookup(input int i, input int hold);
        vec_t v;
        v = VEC[i];
        req_addr = v.va; req_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        if (v.use_mem) begin
            chk($sformatf("R5/R6 v%0d mem_req", i), {63'b0, mem_req}, 64'h1);
            chk($sformatf("R5/R6 v%0d mem_addr", i), mem_addr, v.maddr);
            mem_rvalid = 1'b1; mem_rdata = v.ent; mem_rerr = v.rerr;
            @(posedge clk); @(negedge clk);
            mem_rvalid = 1'b0; mem_rerr = 1'b0;
        end else begin
            chk($sformatf("R4/R6 v%0d no mem read", i), {63'b0, mem_req}, 64'h0);
        end
        for (int h = 0; h <= hold; h++) begin
            chk($sformatf("R10 v%0d rsp_valid", i), {63'b0, rsp_valid}, 64'h1);
            chk($sformatf("R7 v%0d perm", i), {62'b0, rsp_perm}, {62'b0, v.perm});
            chk($sformatf("R8 v%0d pa", i), rsp_pa, v.pa);
            chk($sformatf("R8 v%0d iova", i), rsp_iova, v.iova);
            chk($sformatf("R8 v%0d mask", i), rsp_mask, v.mask);
            if (h < hold) begin
                chk($sformatf("R10 v%0d req_ready low", i), {63'b0, req_ready}, 64'h0);
                @(posedge clk); @(negedge clk);
            end
        end
        rsp_ready = 1'b1;
        @(posedge clk); @(negedge clk);
        rsp_ready = 1'b0;
        chk($sformatf("R10 v%0d back to idle", i), {62'b0, req_ready, rsp_valid}, 64'h2);
    endtask

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [63:0] d;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 req_ready", {63'b0, req_ready}, 64'h1);
        chk("R1 rsp_valid/mem_req", {62'b0, rsp_valid, mem_req}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(5'h00, 1'b1, d); chk("R1 ctrl zero", d, 64'h0);
        rd(5'h08, 1'b1, d); chk("R1 base zero", d, 64'h0);

        // vector table: R4..R9
        for (int i = 0; i < NV; i++) begin
            wr(5'h00, 1'b1, VEC[i].ctrl);
            wr(5'h08, 1'b1, VEC[i].base);
            lookup(i, 0);
        end

        // R10 hold with rsp_ready low for three cycles
        wr(5'h00, 1'b1, VEC[1].ctrl);
        wr(5'h08, 1'b1, VEC[1].base);
        lookup(1, 3);

        // R2 register halves
        wr(5'h00, 1'b1, 64'h1122_3344_5566_7788);
        rd(5'h00, 1'b0, d); chk("R2 upper read", d, 64'h1122_3344);
        rd(5'h04, 1'b0, d); chk("R2 lower read", d, 64'h5566_7788);
        wr(5'h00, 1'b0, 64'hAABB_CCDD);
        rd(5'h00, 1'b1, d); chk("R2 upper write", d, 64'hAABB_CCDD_5566_7788);
        wr(5'h0C, 1'b0, 64'h0BAD_F00D);
        rd(5'h08, 1'b1, d); chk("R2 base lower write", d, 64'h0000_0000_0BAD_F00D);
        wr(5'h04, 1'b1, 64'hFFFF_FFFF_1357_9BDF);
        rd(5'h00, 1'b1, d); chk("R2 +4 lower only", d, 64'hAABB_CCDD_1357_9BDF);

        // R3 flush and unmapped offsets
        wr(5'h10, 1'b1, ONES);
        wr(5'h14, 1'b0, ONES);
        wr(5'h18, 1'b1, ONES);
        rd(5'h10, 1'b1, d); chk("R3 flush reads zero", d, 64'h0);
        rd(5'h18, 1'b1, d); chk("R3 unmapped reads zero", d, 64'h0);
        rd(5'h00, 1'b1, d); chk("R3 ctrl unchanged", d, 64'hAABB_CCDD_1357_9BDF);
        rd(5'h08, 1'b1, d); chk("R3 base unchanged", d, 64'h0000_0000_0BAD_F00D);

        // R1 reset clears registers again
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(5'h00, 1'b1, d); chk("R1 ctrl cleared", d, 64'h0);
        rd(5'h08, 1'b1, d); chk("R1 base cleared", d, 64'h0);
        finish_run();
    end
endmodule